// File: doc/BRIEF.md
# Debug Clock Halt and Step Controller

This block sits between a watch point trigger unit and the clock of a design under debug. It produces an enable that gates the design's clock. A rising trigger interrupt stops the design in the same cycle, so that no further design cycle runs after the event. The design then stays frozen while a host reads back its internal state.

While the design is frozen, the host can advance it by exactly one cycle or by a programmed number of cycles. It then resumes free running by acknowledging the interrupt. The acknowledge is passed on to the trigger unit as a one-cycle pulse so that the trigger unit can clear its condition.

Control is split into two parts. An event machine detects the trigger edge and tracks the outstanding interrupt. A clock machine with the states run, halted and stepping drives the enable. A down counter sets the length of each step burst.

Top module: `dbg_clk_halt_ctl`

## Requirements
- R1: While reset is high and in the first cycle after it, the clock enable is 1, the halted flag is 0 and the forwarded acknowledge is 0.
- R2: In run, a cycle in which the trigger input is 1 after being 0 in the previous cycle has the clock enable at 0 in that same cycle. From the next cycle on, the halted flag is 1 and the enable is 0.
- R3: While halted with no host command, the enable stays 0 and the halted flag stays 1.
- R4: An acknowledge while halted makes the next cycle a run cycle (halted flag 0). The forwarded acknowledge is 1 in that cycle only.
- R5: A single-step command while halted gives exactly one cycle with the enable at 1, then the enable returns to 0.
- R6: A multi-step command with count N (N > 0) while halted gives exactly N consecutive enabled cycles, starting the cycle after the command. The enable then returns to 0.
- R7: Step commands received in run are ignored: the enable stays 1 and the halted flag stays 0.
- R8: A multi-step command with a count of 0 is ignored: the block stays halted with the enable at 0.
- R9: When commands coincide while halted, acknowledge wins over any step, and single-step wins over multi-step.
- R10: Only a trigger edge seen in run halts the design. Edges during halt or stepping are ignored, and a trigger still held at 1 after resuming does not halt again. A fresh edge does.
- R11: An acknowledge received during a step burst is ignored. It does not shorten the burst and produces no forwarded acknowledge.
- R12: The halted flag is 1 in both the halted and the stepping states, and 0 only in run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, free running |
| rst | input | 1 | Synchronous reset, active high |
| trig_irq_i | input | 1 | Watch point interrupt from the trigger unit; its rising edge halts the design |
| host_ack_i | input | 1 | Host acknowledge of the interrupt; resumes run when halted |
| step_one_i | input | 1 | Host command: advance one cycle |
| step_multi_i | input | 1 | Host command: advance step_count_i cycles |
| step_count_i | input | CNT_W | Cycle count for a multi-step command |
| dut_clk_en_o | output | 1 | Clock enable for the design under debug |
| halted_o | output | 1 | 1 whenever the controller is not in run |
| trig_ack_o | output | 1 | One-cycle acknowledge forwarded to the trigger unit |

## Verification
Host commands and the trigger edge can coincide. The interesting collisions are an acknowledge arriving with a step command, and both step commands arriving together. The trigger edge can also coincide with a step command in run, or with the final cycle of a step burst. The bench provokes these collisions directly and also through random command pulses on every input at once. It judges each cycle's enable, halted flag and forwarded acknowledge against a per-cycle reference model derived from the priority and ignore rules.

// File: rtl/dbg_clk_pkg.sv
package dbg_clk_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HALT = 2'd1,
    ST_STEP = 2'd2
  } clk_st_t;

  typedef enum logic {
    EV_IDLE = 1'b0,
    EV_PEND = 1'b1
  } ev_st_t;

endpackage

// File: rtl/dbg_event_fsm.sv
module dbg_event_fsm
  import dbg_clk_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic trig_irq_i,
  input  logic run_i,
  input  logic ack_accept_i,
  output logic halt_req_o,
  output logic trig_ack_o
);

  logic   trig_q;
  ev_st_t ev_q;
  ev_st_t ev_d;

  // previous trigger level, tracked also during reset
  always_ff @(posedge clk) begin
    trig_q <= trig_irq_i;
  end

  // edge only counts while running and no interrupt outstanding
  assign halt_req_o = !rst && run_i && (ev_q == EV_IDLE) && trig_irq_i && !trig_q;

  always_comb begin
    ev_d = ev_q;
    case (ev_q)
      EV_IDLE: if (halt_req_o)   ev_d = EV_PEND;
      EV_PEND: if (ack_accept_i) ev_d = EV_IDLE;
      default: ev_d = EV_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_q       <= EV_IDLE;
      trig_ack_o <= 1'b0;
    end else begin
      ev_q       <= ev_d;
      trig_ack_o <= ack_accept_i;
    end
  end

endmodule

// File: rtl/dbg_step_counter.sv
module dbg_step_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             load_one_i,
  input  logic             dec_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             last_o,
  output logic             count_zero_o
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_one_i ? ONE : count_i;
    end else if (dec_i) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign last_o       = (cnt_q == ONE);
  assign count_zero_o = (count_i == '0);

endmodule

// File: rtl/dbg_clock_fsm.sv
module dbg_clock_fsm
  import dbg_clk_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    halt_req_i,
  input  logic    host_ack_i,
  input  logic    step_one_i,
  input  logic    step_multi_i,
  input  logic    count_zero_i,
  input  logic    last_i,
  output clk_st_t st_o,
  output logic    clk_en_o,
  output logic    ack_accept_o,
  output logic    load_o,
  output logic    load_one_o,
  output logic    dec_o
);

  clk_st_t st_q;
  clk_st_t st_d;

  always_comb begin
    st_d         = st_q;
    clk_en_o     = 1'b0;
    ack_accept_o = 1'b0;
    load_o       = 1'b0;
    load_one_o   = 1'b0;
    dec_o        = 1'b0;
    case (st_q)
      ST_RUN: begin
        clk_en_o = !halt_req_i;
        if (halt_req_i) st_d = ST_HALT;
      end
      ST_HALT: begin
        if (host_ack_i) begin
          ack_accept_o = 1'b1;
          st_d         = ST_RUN;
        end else if (step_one_i) begin
          load_o     = 1'b1;
          load_one_o = 1'b1;
          st_d       = ST_STEP;
        end else if (step_multi_i && !count_zero_i) begin
          load_o = 1'b1;
          st_d   = ST_STEP;
        end
      end
      ST_STEP: begin
        clk_en_o = 1'b1;
        dec_o    = 1'b1;
        if (last_i) st_d = ST_HALT;
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_RUN;
    else     st_q <= st_d;
  end

  assign st_o = st_q;

endmodule

// File: rtl/dbg_clk_halt_ctl.sv
module dbg_clk_halt_ctl
  import dbg_clk_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_irq_i,
  input  logic             host_ack_i,
  input  logic             step_one_i,
  input  logic             step_multi_i,
  input  logic [CNT_W-1:0] step_count_i,
  output logic             dut_clk_en_o,
  output logic             halted_o,
  output logic             trig_ack_o
);

  clk_st_t st;
  logic    halt_req;
  logic    ack_accept;
  logic    load;
  logic    load_one;
  logic    dec;
  logic    last;
  logic    count_zero;

  dbg_event_fsm u_event (
    .clk          (clk),
    .rst          (rst),
    .trig_irq_i   (trig_irq_i),
    .run_i        (st == ST_RUN),
    .ack_accept_i (ack_accept),
    .halt_req_o   (halt_req),
    .trig_ack_o   (trig_ack_o)
  );

  dbg_clock_fsm u_clock (
    .clk          (clk),
    .rst          (rst),
    .halt_req_i   (halt_req),
    .host_ack_i   (host_ack_i),
    .step_one_i   (step_one_i),
    .step_multi_i (step_multi_i),
    .count_zero_i (count_zero),
    .last_i       (last),
    .st_o         (st),
    .clk_en_o     (dut_clk_en_o),
    .ack_accept_o (ack_accept),
    .load_o       (load),
    .load_one_o   (load_one),
    .dec_o        (dec)
  );

  dbg_step_counter #(.CNT_W(CNT_W)) u_count (
    .clk          (clk),
    .rst          (rst),
    .load_i       (load),
    .load_one_i   (load_one),
    .dec_i        (dec),
    .count_i      (step_count_i),
    .last_o       (last),
    .count_zero_o (count_zero)
  );

  assign halted_o = (st != ST_RUN);

endmodule

// File: rtl/dbg_clk_halt_ctl_chk.sv
module dbg_clk_halt_ctl_chk (
  input logic clk,
  input logic rst,
  input logic trig_irq_i,
  input logic host_ack_i,
  input logic step_one_i,
  input logic step_multi_i,
  input logic dut_clk_en_o,
  input logic halted_o,
  input logic trig_ack_o
);

  AST_TRIG_STOPS_NOW: assert property (@(posedge clk) disable iff (rst)
    (!halted_o && $rose(trig_irq_i)) |-> !dut_clk_en_o); // R2

  AST_TRIG_HALTS_NEXT: assert property (@(posedge clk) disable iff (rst)
    (!halted_o && $rose(trig_irq_i)) |=> (halted_o && !dut_clk_en_o)); // R2

  AST_RUN_KEEPS_CLOCK: assert property (@(posedge clk) disable iff (rst)
    (!halted_o && !$rose(trig_irq_i)) |-> dut_clk_en_o); // R7

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (halted_o && !dut_clk_en_o && !host_ack_i && !step_one_i && !step_multi_i)
      |=> (halted_o && !dut_clk_en_o)); // R3

  AST_ACK_RESUMES: assert property (@(posedge clk) disable iff (rst)
    (halted_o && !dut_clk_en_o && host_ack_i) |=> (!halted_o && trig_ack_o)); // R4

  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    trig_ack_o |=> !trig_ack_o); // R4

  AST_ACK_FROM_HALT: assert property (@(posedge clk) disable iff (rst)
    trig_ack_o |-> $past(halted_o && !dut_clk_en_o && host_ack_i)); // R11

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
    (halted_o && !dut_clk_en_o && !host_ack_i && step_one_i)
      |=> (halted_o && dut_clk_en_o) ##1 (halted_o && !dut_clk_en_o)); // R5

  AST_STEP_STAYS_HALTED: assert property (@(posedge clk) disable iff (rst)
    (halted_o && dut_clk_en_o) |=> halted_o); // R12

endmodule

bind dbg_clk_halt_ctl dbg_clk_halt_ctl_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .trig_irq_i   (trig_irq_i),
  .host_ack_i   (host_ack_i),
  .step_one_i   (step_one_i),
  .step_multi_i (step_multi_i),
  .dut_clk_en_o (dut_clk_en_o),
  .halted_o     (halted_o),
  .trig_ack_o   (trig_ack_o)
);

// File: tb/dbg_clk_halt_ctl_bench.sv
`timescale 1ns/1ps
module dbg_clk_halt_ctl_bench;

  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          trig = 1'b0;
  logic          ack = 1'b0;
  logic          one = 1'b0;
  logic          multi = 1'b0;
  logic [CW-1:0] cnt = '0;
  logic          en;
  logic          halted;
  logic          tack;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  // reference model state: 0 run, 1 halted, 2 stepping
  int          m_st  = 0;
  int          m_cnt = 0;
  logic        m_trq = 1'b0;
  logic        m_ack = 1'b0;

  always #2 clk = ~clk;

  dbg_clk_halt_ctl #(.CNT_W(CW)) u_dbg_clk_halt_ctl (
    .clk          (clk),
    .rst          (rst),
    .trig_irq_i   (trig),
    .host_ack_i   (ack),
    .step_one_i   (one),
    .step_multi_i (multi),
    .step_count_i (cnt),
    .dut_clk_en_o (en),
    .halted_o     (halted),
    .trig_ack_o   (tack)
  );

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic exp_en(input logic t);
    if (m_st == 0) return !(t && !m_trq);
    if (m_st == 2) return 1'b1;
    return 1'b0;
  endfunction

  // one cycle: drive, sample, advance the model
  task automatic tick(input logic t, input logic a, input logic o, input logic m,
                      input int n, input string tag);
    @(negedge clk);
    trig = t; ack = a; one = o; multi = m; cnt = CW'(n);
    #1;
    check(tag, "clk_en", en, exp_en(t));
    check(tag, "halted", halted, m_st != 0);
    check(tag, "trig_ack", tack, m_ack);
    m_ack = 1'b0;
    case (m_st)
      0: if (t && !m_trq) m_st = 1;
      1: begin
        if (a) begin m_st = 0; m_ack = 1'b1; end
        else if (o) begin m_st = 2; m_cnt = 1; end
        else if (m && n != 0) begin m_st = 2; m_cnt = n; end
      end
      default: begin
        if (m_cnt == 1) m_st = 1;
        else m_cnt--;
      end
    endcase
    m_trq = t;
  endtask

  task automatic idle(input logic t, input int k, input string tag);
    for (int i = 0; i < k; i++) tick(t, 1'b0, 1'b0, 1'b0, 0, tag);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check("R1", "clk_en in reset", en, 1'b1);
    check("R1", "halted in reset", halted, 1'b0);
    check("R1", "trig_ack in reset", tack, 1'b0);
    @(negedge clk); rst = 1'b0;
    #1;
    check("R1", "clk_en after reset", en, 1'b1);
    check("R1", "halted after reset", halted, 1'b0);
    idle(1'b0, 2, "R1");
    // step commands in run
    tick(1'b0, 1'b0, 1'b1, 1'b0, 0, "R7");
    tick(1'b0, 1'b0, 1'b0, 1'b1, 9, "R7");
    idle(1'b0, 2, "R7");
    // trigger edge, then held
    tick(1'b1, 1'b0, 1'b0, 1'b0, 0, "R2");
    idle(1'b1, 4, "R3");
    // single step
    tick(1'b1, 1'b0, 1'b1, 1'b0, 0, "R5");
    idle(1'b1, 3, "R5");
    // multi step 5, with ack and trigger edge inside the burst
    tick(1'b0, 1'b0, 1'b0, 1'b1, 5, "R6");
    tick(1'b0, 1'b1, 1'b0, 1'b0, 0, "R11");
    tick(1'b1, 1'b0, 1'b0, 1'b0, 0, "R10");
    idle(1'b1, 5, "R6");
    // zero count
    tick(1'b1, 1'b0, 1'b0, 1'b1, 0, "R8");
    idle(1'b1, 2, "R8");
    // ack wins over steps; held trigger does not rehalt
    tick(1'b1, 1'b1, 1'b1, 1'b1, 3, "R9");
    idle(1'b1, 4, "R10");
    tick(1'b0, 1'b0, 1'b0, 1'b0, 0, "R10");
    tick(1'b1, 1'b0, 1'b0, 1'b0, 0, "R2");
    idle(1'b0, 2, "R12");
    // single wins over multi
    tick(1'b0, 1'b0, 1'b1, 1'b1, 7, "R9");
    idle(1'b0, 3, "R9");
    // long burst, multi count of one
    tick(1'b0, 1'b0, 1'b0, 1'b1, 300, "R6");
    idle(1'b0, 303, "R6");
    tick(1'b0, 1'b0, 1'b0, 1'b1, 1, "R6");
    idle(1'b0, 3, "R6");
    tick(1'b0, 1'b1, 1'b0, 1'b0, 0, "R4");
    idle(1'b0, 3, "R4");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic t_r, a_r, o_r, m_r;
      t_r = ($urandom % 8 == 0) ? !m_trq : m_trq;
      a_r = ($urandom % 12 == 0);
      o_r = ($urandom % 10 == 0);
      m_r = ($urandom % 10 == 0);
      tick(t_r, a_r, o_r, m_r, int'($urandom % 20), "R12");
    end
    done = 1'b1;
    summary();
    $finish;
  end

endmodule